// File: doc/BRIEF.md
# Processor idle-state sequencer

This controller moves a processor core between its single executing state (C0) and six idle levels of growing depth. Software policy elsewhere picks a target level and presents it on a request port. The controller then turns off the matching resources one at a time, in a fixed order: cache power, core clock, PLL, and the front-side bus interface. At the deepest level it first asks an external agent to save the core state. A wake event runs the mirrored exit: clocks first, then the bus, then the state restore, then a one-cycle pipeline restart.

Each step that has a partner waits for that partner's acknowledge before it moves on. Two watch counters raise sticky flags. One fires when a single step waits too long for its acknowledge. The other fires when a wake takes longer than its cycle budget to get back to C0. Caches that lost power are never reloaded in bulk. The controller emits an invalidate strobe together with the pipeline restart, and lines then refill on demand.

Top module: `idle_seq`

## Requirements
- R1: After reset the block is in C0. `cstate` = 0, `busy` = 0, all four enables are 1, and every request, strobe and flag output is 0.
- R2: A request (`req_valid` = 1) is accepted only in C0, and only with `req_level` in 1..DEEP_LVL (6 by default). A level of 0 or above DEEP_LVL, or a request made outside C0, has no effect.
- R3: Resources follow the target level. Cache power is off for levels ≥ 2. The core clock is off for levels ≥ 3. The PLL is also off for levels ≥ 5. The bus interface is off only at level 6. In C0 all four are on.
- R4: Entry to level 6 runs these steps in order: save (`save_req` high until `save_ack`), cache off, clock stop (held until `clk_ack`), bus off (held until `bus_ack`), then idle. Shallower levels use the matching subset of these steps, in the same order.
- R5: Exit runs these steps in order, skipping any whose entry step was never taken: clock restart (until `clk_ack`), bus on (until `bus_ack`), restore (`restore_req` until `restore_ack`), then one cycle of `pipe_restart`, then C0.
- R6: A wake that arrives during entry lets the current step finish. The exit then starts directly from that point, and the idle state is never reached. This also holds when the wake and the step's acknowledge arrive in the same cycle.
- R7: A wake in C0 or during exit has no effect.
- R8: `cache_inval` pulses together with `pipe_restart` only when cache power had been turned off. Cache power returns on the cycle the block re-enters C0.
- R9: `ack_timeout` sets when one step waits STEP_LIMIT cycles in a row without its acknowledge. It stays set until the next accepted request.
- R10: `wake_late` sets if more than WAKE_BUDGET cycles pass between the edge that samples the wake and the edge that re-enters C0. It stays set until the next accepted request.
- R11: `cstate` shows 0 in C0 and the accepted level everywhere else. `busy` is 1 during entry and exit steps and 0 in C0 and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Idle-level request strobe |
| req_level | input | LVL_W | Requested idle level |
| wake | input | 1 | Wake event |
| save_ack | input | 1 | State save finished |
| restore_ack | input | 1 | State restore finished |
| clk_ack | input | 1 | Clock generator reached its new state |
| bus_ack | input | 1 | Bus interface reached its new state |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| cache_pwr_en | output | 1 | Cache power enable |
| bus_en | output | 1 | Front-side bus interface enable |
| save_req | output | 1 | State save request |
| restore_req | output | 1 | State restore request |
| pipe_restart | output | 1 | One-cycle pipeline restart strobe |
| cache_inval | output | 1 | Clear all cache valid bits |
| cstate | output | LVL_W | Current state, 0 = C0 |
| busy | output | 1 | Sequence step in progress |
| ack_timeout | output | 1 | Sticky missing-acknowledge flag |
| wake_late | output | 1 | Sticky wake-budget overrun flag |

## Verification
The delicate overlap is a wake that lands in the same cycle as the acknowledge that ends an entry step. In that cycle the controller must choose the exit path and skip the next entry step. The bench provokes this by holding `bus_ack` low during a level-6 entry and then raising `bus_ack` and `wake` together for one cycle. A reference model built from step queues predicts every output on every cycle, and a monitor confirms that the idle state was never shown. A second overlap comes from a stalled exit step, where the step timeout and the wake budget count in the same cycles. The bench checks that each flag rises on its own cycle.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  typedef enum logic [3:0] {
    PH_ACTIVE,
    PH_SAVE,
    PH_CACHE,
    PH_CLK,
    PH_BUS,
    PH_IDLE,
    PH_XCLK,
    PH_XBUS,
    PH_XREST,
    PH_XRESTART
  } phase_e;

  // Steps that hold until a partner acknowledges.
  function automatic logic needs_ack(phase_e p);
    return p inside {PH_SAVE, PH_CLK, PH_BUS, PH_XCLK, PH_XBUS, PH_XREST};
  endfunction

  function automatic logic is_entry(phase_e p);
    return p inside {PH_SAVE, PH_CACHE, PH_CLK, PH_BUS};
  endfunction

endpackage

// File: rtl/idle_seq_watch.sv
module idle_seq_watch #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic flag_clr,
  output logic flag
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  function automatic logic reaches(logic [CW-1:0] c);
    return (c + CW'(1)) == LIM;
  endfunction

  logic hit;
  assign hit = run && !clear && reaches(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (clear)                 cnt <= '0;
      else if (run && cnt < LIM) cnt <= cnt + CW'(1);
      if (flag_clr)  flag <= 1'b0;
      else if (hit)  flag <= 1'b1;
    end
  end

  // R9 / R10: the counter never runs past its limit
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  // R9 / R10: the flag only rises after a counted cycle
  assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(run));

endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
  import idle_seq_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int DEEP_LVL  = 6,
  parameter int CACHE_LVL = 2,
  parameter int CLK_LVL   = 3,
  parameter int PLL_LVL   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             wake,
  input  logic             save_ack,
  input  logic             restore_ack,
  input  logic             clk_ack,
  input  logic             bus_ack,
  output phase_e           phase_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             accept_o,
  output logic             step_change_o,
  output logic             ack_wait_o,
  output logic             wake_start_o,
  output logic             wake_run_o,
  output logic             clk_off_o,
  output logic             pll_off_o,
  output logic             cache_off_o,
  output logic             bus_off_o
);
  localparam logic [LVL_W-1:0] L_DEEP  = LVL_W'(DEEP_LVL);
  localparam logic [LVL_W-1:0] L_CACHE = LVL_W'(CACHE_LVL);
  localparam logic [LVL_W-1:0] L_CLK   = LVL_W'(CLK_LVL);
  localparam logic [LVL_W-1:0] L_PLL   = LVL_W'(PLL_LVL);

  phase_e           phase, nxt;
  logic [LVL_W-1:0] lvl;
  logic             clk_off, pll_off, cache_off, bus_off, saved, wake_act;
  logic             ack_ok, level_ok, accept, wake_start, step_change;

  // Next entry step after cur for target level lv.
  function automatic phase_e entry_next(phase_e cur, logic [LVL_W-1:0] lv);
    logic pre_cache, pre_clk, pre_bus;
    pre_cache = (cur == PH_ACTIVE) || (cur == PH_SAVE);
    pre_clk   = pre_cache || (cur == PH_CACHE);
    pre_bus   = pre_clk || (cur == PH_CLK);
    if (cur == PH_ACTIVE && lv == L_DEEP) return PH_SAVE;
    if (pre_cache && lv >= L_CACHE)       return PH_CACHE;
    if (pre_clk && lv >= L_CLK)           return PH_CLK;
    if (pre_bus && lv == L_DEEP)          return PH_BUS;
    return PH_IDLE;
  endfunction

  // First undo step still outstanding.
  function automatic phase_e exit_from(logic c_off, logic b_off, logic sv);
    if (c_off) return PH_XCLK;
    if (b_off) return PH_XBUS;
    if (sv)    return PH_XREST;
    return PH_XRESTART;
  endfunction

  always_comb begin
    unique case (phase)
      PH_SAVE:           ack_ok = save_ack;
      PH_CLK, PH_XCLK:   ack_ok = clk_ack;
      PH_BUS, PH_XBUS:   ack_ok = bus_ack;
      PH_XREST:          ack_ok = restore_ack;
      default:           ack_ok = 1'b1;
    endcase
  end

  assign level_ok   = (req_level != '0) && (req_level <= L_DEEP);
  assign accept     = (phase == PH_ACTIVE) && req_valid && level_ok;
  assign wake_start = wake && !wake_act && (is_entry(phase) || phase == PH_IDLE);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_ACTIVE:   if (accept) nxt = entry_next(PH_ACTIVE, req_level);
      PH_SAVE, PH_CACHE, PH_CLK, PH_BUS:
        if (ack_ok) nxt = (wake || wake_act) ? exit_from(clk_off, bus_off, saved)
                                             : entry_next(phase, lvl);
      PH_IDLE:     if (wake) nxt = exit_from(clk_off, bus_off, saved);
      PH_XCLK, PH_XBUS, PH_XREST:
        if (ack_ok) nxt = exit_from(clk_off, bus_off, saved);
      PH_XRESTART: nxt = PH_ACTIVE;
      default:     nxt = PH_ACTIVE;
    endcase
  end

  assign step_change = (nxt != phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_ACTIVE;
      lvl       <= '0;
      clk_off   <= 1'b0;
      pll_off   <= 1'b0;
      cache_off <= 1'b0;
      bus_off   <= 1'b0;
      saved     <= 1'b0;
      wake_act  <= 1'b0;
    end else begin
      phase <= nxt;
      if (accept) lvl <= req_level;
      if (wake_start)                  wake_act <= 1'b1;
      else if (phase == PH_XRESTART)   wake_act <= 1'b0;
      // Resource flags change on the edge that enters a step.
      if (step_change) begin
        unique case (nxt)
          PH_SAVE:   saved     <= 1'b1;
          PH_CACHE:  cache_off <= 1'b1;
          PH_CLK: begin
            clk_off <= 1'b1;
            pll_off <= (lvl >= L_PLL);
          end
          PH_BUS:    bus_off   <= 1'b1;
          PH_XCLK: begin
            clk_off <= 1'b0;
            pll_off <= 1'b0;
          end
          PH_XBUS:   bus_off   <= 1'b0;
          PH_XREST:  saved     <= 1'b0;
          PH_ACTIVE: cache_off <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign phase_o       = phase;
  assign lvl_o         = lvl;
  assign accept_o      = accept;
  assign step_change_o = step_change;
  assign ack_wait_o    = needs_ack(phase) && !ack_ok;
  assign wake_start_o  = wake_start;
  assign wake_run_o    = wake_act && (phase != PH_XRESTART);
  assign clk_off_o     = clk_off;
  assign pll_off_o     = pll_off;
  assign cache_off_o   = cache_off;
  assign bus_off_o     = bus_off;

  // R3: in C0 every resource is back on and nothing is saved
  assert_active_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE) |-> (!clk_off && !pll_off && !bus_off && !cache_off && !saved));

  // R4: the bus goes down only after the clock has stopped
  assert_bus_after_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> clk_off);

  // R4: at the deepest level the state is saved before the clock stops
  assert_save_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_off) && lvl == L_DEEP) |-> saved);

  // R5: the bus comes back only after the clock has restarted
  assert_clk_before_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> !clk_off);

  // R5: the restore runs with clocks and bus up
  assert_restore_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_XREST) |-> (!clk_off && !bus_off));

  // R2: the level is frozen outside C0
  assert_lvl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_ACTIVE) |=> $stable(lvl));

  // R8: cache power returns only on leaving the restart step
  assert_cache_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cache_off) |-> $past(phase == PH_XRESTART));

endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_seq_pkg::*;
#(
  parameter int LVL_W       = 3,
  parameter int DEEP_LVL    = 6,
  parameter int CACHE_LVL   = 2,
  parameter int CLK_LVL     = 3,
  parameter int PLL_LVL     = 5,
  parameter int WAKE_BUDGET = 10000,
  parameter int STEP_LIMIT  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             wake,
  input  logic             save_ack,
  input  logic             restore_ack,
  input  logic             clk_ack,
  input  logic             bus_ack,
  output logic             core_clk_en,
  output logic             pll_en,
  output logic             cache_pwr_en,
  output logic             bus_en,
  output logic             save_req,
  output logic             restore_req,
  output logic             pipe_restart,
  output logic             cache_inval,
  output logic [LVL_W-1:0] cstate,
  output logic             busy,
  output logic             ack_timeout,
  output logic             wake_late
);
  phase_e           phase;
  logic [LVL_W-1:0] lvl;
  logic accept, step_change, ack_wait, wake_start, wake_run;
  logic clk_off, pll_off, cache_off, bus_off;

  idle_seq_fsm #(
    .LVL_W(LVL_W), .DEEP_LVL(DEEP_LVL), .CACHE_LVL(CACHE_LVL),
    .CLK_LVL(CLK_LVL), .PLL_LVL(PLL_LVL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .wake(wake), .save_ack(save_ack), .restore_ack(restore_ack),
    .clk_ack(clk_ack), .bus_ack(bus_ack),
    .phase_o(phase), .lvl_o(lvl), .accept_o(accept),
    .step_change_o(step_change), .ack_wait_o(ack_wait),
    .wake_start_o(wake_start), .wake_run_o(wake_run),
    .clk_off_o(clk_off), .pll_off_o(pll_off),
    .cache_off_o(cache_off), .bus_off_o(bus_off)
  );

  // Per-step acknowledge watch
  idle_seq_watch #(.LIMIT(STEP_LIMIT)) u_step_watch (
    .clk(clk), .rst_n(rst_n), .clear(step_change), .run(ack_wait),
    .flag_clr(accept), .flag(ack_timeout)
  );

  // Wake-to-C0 budget watch
  idle_seq_watch #(.LIMIT(WAKE_BUDGET)) u_wake_watch (
    .clk(clk), .rst_n(rst_n), .clear(wake_start), .run(wake_run),
    .flag_clr(accept), .flag(wake_late)
  );

  assign core_clk_en  = !clk_off;
  assign pll_en       = !pll_off;
  assign cache_pwr_en = !cache_off;
  assign bus_en       = !bus_off;
  assign save_req     = (phase == PH_SAVE);
  assign restore_req  = (phase == PH_XREST);
  assign pipe_restart = (phase == PH_XRESTART);
  assign cache_inval  = pipe_restart && cache_off;
  assign cstate       = (phase == PH_ACTIVE) ? '0 : lvl;
  assign busy         = (phase != PH_ACTIVE) && (phase != PH_IDLE);

endmodule

// File: tb/idle_seq_bench.sv
module idle_seq_bench;
  localparam int BUDGET = 10;
  localparam int SLIM   = 6;
  localparam int DEEP   = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, wake = 0;
  logic [2:0] req_level = 0;
  logic save_ack = 1, restore_ack = 1, clk_ack = 1, bus_ack = 1;
  logic core_clk_en, pll_en, cache_pwr_en, bus_en, save_req, restore_req;
  logic pipe_restart, cache_inval, busy, ack_timeout, wake_late;
  logic [2:0] cstate;

  always #5 clk = ~clk;

  idle_seq #(.WAKE_BUDGET(BUDGET), .STEP_LIMIT(SLIM)) u_idle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .wake(wake), .save_ack(save_ack), .restore_ack(restore_ack),
    .clk_ack(clk_ack), .bus_ack(bus_ack),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .cache_pwr_en(cache_pwr_en),
    .bus_en(bus_en), .save_req(save_req), .restore_req(restore_req),
    .pipe_restart(pipe_restart), .cache_inval(cache_inval), .cstate(cstate),
    .busy(busy), .ack_timeout(ack_timeout), .wake_late(wake_late)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  // step codes
  localparam int S_SAVE = 1, S_CACHE = 2, S_CLK = 3, S_BUS = 4;
  localparam int X_CLK = 11, X_BUS = 12, X_REST = 13, X_RESTART = 14;
  int q[$];
  int m_mode = 0;  // 0 C0, 1 entering, 2 idle, 3 exiting
  int m_lvl = 0;
  bit m_cache, m_clk, m_pll, m_bus, m_saved, m_won, m_tmo, m_late;
  int scnt = 0, wcnt = 0;

  task automatic act_on(int s);
    case (s)
      S_SAVE:  m_saved = 1;
      S_CACHE: m_cache = 1;
      S_CLK:   begin m_clk = 1; m_pll = (m_lvl >= 5); end
      S_BUS:   m_bus = 1;
      X_CLK:   begin m_clk = 0; m_pll = 0; end
      X_BUS:   m_bus = 0;
      X_REST:  m_saved = 0;
      default: ;
    endcase
  endtask

  task automatic go_exit();
    q.delete();
    if (m_clk)   q.push_back(X_CLK);
    if (m_bus)   q.push_back(X_BUS);
    if (m_saved) q.push_back(X_REST);
    q.push_back(X_RESTART);
    m_mode = 3;
    act_on(q[0]);
  endtask

  function automatic bit ack_of(int s);
    case (s)
      S_SAVE:        return save_ack;
      S_CLK, X_CLK:  return clk_ack;
      S_BUS, X_BUS:  return bus_ack;
      X_REST:        return restore_ack;
      default:       return 1;
    endcase
  endfunction

  function automatic bit acked_step(int s);
    return s inside {S_SAVE, S_CLK, S_BUS, X_CLK, X_BUS, X_REST};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_mode = 0; m_lvl = 0;
      {m_cache, m_clk, m_pll, m_bus, m_saved, m_won, m_tmo, m_late} = '0;
      scnt = 0; wcnt = 0;
    end else begin
      bit won_old;
      won_old = m_won;
      case (m_mode)
        0: if (req_valid && req_level >= 1 && req_level <= DEEP) begin
             m_lvl = req_level; m_tmo = 0; m_late = 0; scnt = 0;
             q.delete();
             if (m_lvl == DEEP) q.push_back(S_SAVE);
             if (m_lvl >= 2)    q.push_back(S_CACHE);
             if (m_lvl >= 3)    q.push_back(S_CLK);
             if (m_lvl == DEEP) q.push_back(S_BUS);
             if (q.size() == 0) m_mode = 2;
             else begin m_mode = 1; act_on(q[0]); end
           end
        1: begin
             if (won_old) begin wcnt++; if (wcnt == BUDGET) m_late = 1; end
             else if (wake) begin m_won = 1; wcnt = 0; end
             if (ack_of(q[0])) begin
               void'(q.pop_front());
               scnt = 0;
               if (wake || won_old) go_exit();
               else if (q.size() == 0) m_mode = 2;
               else act_on(q[0]);
             end else if (acked_step(q[0])) begin
               scnt++; if (scnt == SLIM) m_tmo = 1;
             end
           end
        2: if (wake) begin m_won = 1; wcnt = 0; scnt = 0; go_exit(); end
        default: begin
             if (won_old && q[0] != X_RESTART) begin
               wcnt++; if (wcnt == BUDGET) m_late = 1;
             end
             if (ack_of(q[0])) begin
               scnt = 0;
               if (q[0] == X_RESTART) begin
                 m_cache = 0; m_won = 0; m_mode = 0; q.delete();
               end else begin
                 void'(q.pop_front()); act_on(q[0]);
               end
             end else if (acked_step(q[0])) begin
               scnt++; if (scnt == SLIM) m_tmo = 1;
             end
           end
      endcase
    end
  end

  // ---------------- per-cycle compare and monitor ----------------
  int ncyc = 0;
  int ev_save, ev_clkoff, ev_busoff, ev_clkon, ev_buson, ev_rest, ev_restart;
  int n_inval = 0;
  bit saw_idle = 0;

  task automatic clear_ev();
    ev_save = -1; ev_clkoff = -1; ev_busoff = -1;
    ev_clkon = -1; ev_buson = -1; ev_rest = -1; ev_restart = -1;
    n_inval = 0; saw_idle = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit hd;
      hd = (q.size() > 0);
      check("R3 core_clk_en", core_clk_en, !m_clk);
      check("R3 pll_en", pll_en, !m_pll);
      check("R3 cache_pwr_en", cache_pwr_en, !m_cache);
      check("R3 bus_en", bus_en, !m_bus);
      check("R4 save_req", save_req, m_mode == 1 && hd && q[0] == S_SAVE);
      check("R5 restore_req", restore_req, m_mode == 3 && hd && q[0] == X_REST);
      check("R5 pipe_restart", pipe_restart, m_mode == 3 && hd && q[0] == X_RESTART);
      check("R8 cache_inval", cache_inval, m_mode == 3 && hd && q[0] == X_RESTART && m_cache);
      check("R11 cstate", cstate, m_mode == 0 ? 0 : m_lvl);
      check("R11 busy", busy, m_mode == 1 || m_mode == 3);
      check("R9 ack_timeout", ack_timeout, m_tmo);
      check("R10 wake_late", wake_late, m_late);
      ncyc++;
      if (save_req && ev_save < 0) ev_save = ncyc;
      if (!core_clk_en && ev_clkoff < 0) ev_clkoff = ncyc;
      if (!bus_en && ev_busoff < 0) ev_busoff = ncyc;
      if (ev_clkoff >= 0 && core_clk_en && ev_clkon < 0) ev_clkon = ncyc;
      if (ev_busoff >= 0 && bus_en && ev_buson < 0) ev_buson = ncyc;
      if (restore_req && ev_rest < 0) ev_rest = ncyc;
      if (pipe_restart && ev_restart < 0) ev_restart = ncyc;
      if (cache_inval) n_inval++;
      if (cstate != 0 && !busy) saw_idle = 1;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic request(int lv);
    req_level = 3'(lv); req_valid = 1; cyc(); req_valid = 0;
  endtask

  task automatic pulse_wake();
    wake = 1; cyc(); wake = 0;
  endtask

  initial begin
    clear_ev();
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 cstate", cstate, 0);
    check("R1 busy", busy, 0);
    check("R1 enables", {core_clk_en, pll_en, cache_pwr_en, bus_en}, 4'hF);
    check("R1 strobes", {save_req, restore_req, pipe_restart, cache_inval, ack_timeout, wake_late}, 0);
    cyc();

    // R7 wake in C0 ignored
    pulse_wake();
    @(negedge clk);
    check("R7 wake in C0", {busy, pipe_restart, 3'(cstate)}, 0);
    cyc();

    // R2 invalid levels ignored
    request(0); @(negedge clk); check("R2 level 0", {busy, 3'(cstate)}, 0); cyc();
    request(7); @(negedge clk); check("R2 level 7", {busy, 3'(cstate)}, 0); cyc();

    // level 1: no cache loss, no invalidate (R8)
    clear_ev();
    request(1); cyc(3);
    pulse_wake(); cyc(4);
    check("R8 no inval after level 1", n_inval, 0);
    check("R5 restart after level 1", ev_restart > 0, 1);

    // level 6 full sequence, acks immediate
    clear_ev();
    request(6); cyc(6);
    request(2);                                      // R2 ignored while idle
    @(negedge clk); check("R2 request while idle", cstate, 6); cyc();
    pulse_wake(); cyc(8);
    check("R4 save before clock stop", ev_save < ev_clkoff && ev_save > 0, 1);
    check("R4 clock stop before bus off", ev_clkoff < ev_busoff, 1);
    check("R5 clock before bus on", ev_clkon > 0 && ev_clkon < ev_buson, 1);
    check("R5 bus before restore", ev_buson < ev_rest, 1);
    check("R5 restore before restart", ev_rest < ev_restart, 1);
    check("R8 one inval after level 6", n_inval, 1);
    check("R10 within budget", wake_late, 0);

    // level 6 with a slow save acknowledge, request during entry ignored
    save_ack = 0; request(6); cyc(2);
    request(3); cyc(1);
    @(negedge clk); check("R2 request during entry", cstate, 6);
    save_ack = 1; cyc(6);
    pulse_wake(); cyc(8);

    // R6 wake mid entry while clock stop waits
    clear_ev();
    clk_ack = 0; request(3); cyc(2);
    pulse_wake(); cyc(1); clk_ack = 1; cyc(6);
    check("R6 idle never shown (level 3)", saw_idle, 0);
    check("R6 exit completed", ev_restart > 0, 1);

    // R6 wake and acknowledge in the same cycle
    clear_ev();
    bus_ack = 0; request(6); cyc(4);
    bus_ack = 1; wake = 1; cyc(); wake = 0; cyc(8);
    check("R6 idle never shown (same cycle)", saw_idle, 0);
    check("R6 bus restored", bus_en, 1);

    // R9 step timeout, then R7 wake during exit ignored
    bus_ack = 0; request(6); cyc(4 + SLIM + 2);
    @(negedge clk); check("R9 timeout raised", ack_timeout, 1);
    bus_ack = 1; cyc(2);
    restore_ack = 0; pulse_wake(); cyc(3);
    pulse_wake(); cyc(1);
    @(negedge clk); check("R7 wake during exit", restore_req, 1);
    // R10 budget overrun
    cyc(BUDGET);
    @(negedge clk); check("R10 late raised", wake_late, 1);
    restore_ack = 1; cyc(4);
    request(2); cyc(1);
    @(negedge clk); check("R10 cleared on accept", {wake_late, ack_timeout}, 0);
    cyc(2); pulse_wake(); cyc(4);
    @(negedge clk); check("R11 back in C0", {busy, 3'(cstate)}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule